// File: doc/BRIEF.md
# Power-on configuration sequencer

This block runs the start-up of a configuration controller. Once reset is released it fetches a fixed 32-word block of 16-bit option words from flash, one word at a time, through a request/valid read port. It keeps the word that holds the mode fields and the eight page start offsets. It then captures a 3-bit page select input a single time.

Next it waits until the target device is ready: status_n must be high and conf_done must be low. It then raises a start command toward the data transmit unit, together with the start address of the selected page and the decoded mode settings. While the transfer runs it watches the target. A low status_n ends the run in a sticky error state. A rising conf_done ends it in a sticky done state. Decompression and the shifting of data bits belong to other blocks.

Top module: `cfg_boot_seq`

## Requirements
- R1: After reset the block issues exactly 32 flash reads, at word addresses 0x8000 through 0x801F in ascending order. Only one read is outstanding at a time, and flash_addr stays stable while flash_req is high and flash_valid is low.
- R2: While rst_n is low, flash_req, xfer_start, cfg_done and cfg_error are all low.
- R3: Option word 0 is decoded as follows: bits [2:0] drive xfer_mode, bits [7:4] drive xfer_clk_sel and bit 8 drives xfer_decomp.
- R4: xfer_lanes gives the number of data lanes per transfer clock for each mode code: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 4 (byte-parallel) gives 8. The reserved codes 5 to 7 give 1.
- R5: xfer_addr is option word 1+p, zero-extended, where p is the captured page select value.
- R6: page_sel is captured once, on the clock edge after the last option word is accepted. Later changes to page_sel have no effect on xfer_addr.
- R7: xfer_start rises only on the clock edge after status_n is seen high with conf_done low, and never before all option words are read. If conf_done is high while the block is waiting, the transfer does not start.
- R8: If status_n is low while xfer_start is high, on the next cycle xfer_start is low and cfg_error is high. cfg_error then stays high until reset.
- R9: If conf_done is high and status_n is high while xfer_start is high, on the next cycle xfer_start is low and cfg_done is high. cfg_done then stays high until reset.
- R10: If status_n falls and conf_done rises in the same cycle during a transfer, the block takes the error outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| page_sel | input | 3 | Page select, captured once per reset |
| status_n | input | 1 | Target status, low means fault or not ready |
| conf_done | input | 1 | Target reports configuration complete |
| flash_req | output | 1 | Flash read request |
| flash_addr | output | 20 | Flash word address |
| flash_valid | input | 1 | Read data valid, completes the request |
| flash_rdata | input | 16 | Read data word |
| xfer_start | output | 1 | Start command to the transmit unit |
| xfer_addr | output | 20 | Start word offset of the selected page |
| xfer_mode | output | 3 | Configuration scheme code |
| xfer_lanes | output | 4 | Data lanes per transfer clock |
| xfer_clk_sel | output | 4 | Transfer clock speed select |
| xfer_decomp | output | 1 | Decompression enable |
| cfg_done | output | 1 | Configuration finished |
| cfg_error | output | 1 | Target reported an error during transfer |

## Verification
The hardest situation to reach from the ports is a change of page_sel after it has been captured. The bench has to count accepted flash reads to know when capture has happened, so it holds status_n low to keep the block waiting and then moves page_sel before it releases readiness. The same-cycle collision of a falling status_n and a rising conf_done is also rare. The bench waits for the start command and then drives both inputs at one falling edge. The flash model uses a different response latency in each run, so the read order and address hold are checked under several timings.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_PAGE,
    ST_WAIT,
    ST_CFG,
    ST_DONE,
    ST_ERR
  } seq_st_t;

  typedef struct packed {
    logic [2:0] mode;
    logic [3:0] clk_sel;
    logic       decomp;
  } opt_cfg_t;

  // Field split of option word 0 (low nine bits).
  function automatic opt_cfg_t decode_cfg(input logic [8:0] w);
    opt_cfg_t c;
    c.mode    = w[2:0];
    c.clk_sel = w[7:4];
    c.decomp  = w[8];
    return c;
  endfunction

  // Lanes per transfer clock for a mode code.
  function automatic logic [3:0] lanes_of(input logic [2:0] m);
    logic [3:0] n;
    case (m)
      3'd0:    n = 4'd1;
      3'd1:    n = 4'd2;
      3'd2:    n = 4'd4;
      3'd3:    n = 4'd8;
      3'd4:    n = 4'd8;
      default: n = 4'd1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/cfg_opt_fetch.sv
module cfg_opt_fetch #(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int NOPT   = 32,
  parameter logic [AW-1:0] BASE = 20'h08000,
  localparam int IDX_W = $clog2(NOPT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  output logic             flash_req,
  output logic [AW-1:0]    flash_addr,
  input  logic             flash_valid,
  input  logic [DW-1:0]    flash_rdata,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [DW-1:0]    wr_data,
  output logic             opt_last
);

  logic [IDX_W-1:0] idx_q;

  assign flash_req  = active;
  assign flash_addr = BASE + AW'(idx_q);
  assign wr_en      = active && flash_valid;
  assign wr_idx     = idx_q;
  assign wr_data    = flash_rdata;
  assign opt_last   = wr_en && (idx_q == IDX_W'(NOPT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (wr_en) idx_q <= idx_q + 1'b1;
  end

endmodule

// File: rtl/cfg_opt_store.sv
module cfg_opt_store
  import cfg_boot_pkg::*;
#(
  parameter int DW     = 16,
  parameter int NOPT   = 32,
  parameter int NPAGE  = 8,
  localparam int IDX_W = $clog2(NOPT),
  localparam int PSEL_W = $clog2(NPAGE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [PSEL_W-1:0] page_q,
  output opt_cfg_t          cfg,
  output logic [DW-1:0]     page_word
);

  logic [DW-1:0] pg_q [NPAGE];
  opt_cfg_t      cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      for (int p = 0; p < NPAGE; p++) pg_q[p] <= '0;
    end else if (wr_en) begin
      if (wr_idx == '0) cfg_q <= decode_cfg(wr_data[8:0]);
      for (int p = 0; p < NPAGE; p++)
        if (wr_idx == IDX_W'(p + 1)) pg_q[p] <= wr_data;
    end
  end

  assign cfg       = cfg_q;
  assign page_word = pg_q[page_q];

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_boot_pkg::*;
#(
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opt_last,
  input  logic              status_n,
  input  logic              conf_done,
  input  logic [PSEL_W-1:0] page_sel,
  output seq_st_t           state,
  output logic              page_cap,
  output logic [PSEL_W-1:0] page_q
);

  seq_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: st_d = ST_READ;
      ST_READ: if (opt_last) st_d = ST_PAGE;
      ST_PAGE: st_d = ST_WAIT;
      ST_WAIT: if (status_n && !conf_done) st_d = ST_CFG;
      ST_CFG: begin
        if (!status_n)     st_d = ST_ERR;
        else if (conf_done) st_d = ST_DONE;
      end
      default: st_d = st_q;
    endcase
  end

  assign page_cap = (st_q == ST_PAGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      page_q <= '0;
    end else begin
      st_q <= st_d;
      if (page_cap) page_q <= page_sel;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
  import cfg_boot_pkg::*;
#(
  parameter int AW    = 20,
  parameter int DW    = 16,
  parameter int NOPT  = 32,
  parameter int NPAGE = 8,
  parameter logic [AW-1:0] BASE = 20'h08000,
  localparam int IDX_W  = $clog2(NOPT),
  localparam int PSEL_W = $clog2(NPAGE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PSEL_W-1:0] page_sel,
  input  logic              status_n,
  input  logic              conf_done,
  output logic              flash_req,
  output logic [AW-1:0]     flash_addr,
  input  logic              flash_valid,
  input  logic [DW-1:0]     flash_rdata,
  output logic              xfer_start,
  output logic [AW-1:0]     xfer_addr,
  output logic [2:0]        xfer_mode,
  output logic [3:0]        xfer_lanes,
  output logic [3:0]        xfer_clk_sel,
  output logic              xfer_decomp,
  output logic              cfg_done,
  output logic              cfg_error
);

  seq_st_t           state;
  logic              opt_last;
  logic              page_cap;
  logic [PSEL_W-1:0] page_q;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DW-1:0]     wr_data;
  opt_cfg_t          cfg;
  logic [DW-1:0]     page_word;

  cfg_opt_fetch #(.AW(AW), .DW(DW), .NOPT(NOPT), .BASE(BASE)) fetch_i (
    .clk(clk), .rst_n(rst_n), .active(state == ST_READ),
    .flash_req(flash_req), .flash_addr(flash_addr),
    .flash_valid(flash_valid), .flash_rdata(flash_rdata),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .opt_last(opt_last)
  );

  cfg_opt_store #(.DW(DW), .NOPT(NOPT), .NPAGE(NPAGE)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .page_q(page_q), .cfg(cfg), .page_word(page_word)
  );

  cfg_seq_fsm #(.PSEL_W(PSEL_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .opt_last(opt_last), .status_n(status_n),
    .conf_done(conf_done), .page_sel(page_sel), .state(state),
    .page_cap(page_cap), .page_q(page_q)
  );

  assign xfer_start   = (state == ST_CFG);
  assign cfg_done     = (state == ST_DONE);
  assign cfg_error    = (state == ST_ERR);
  assign xfer_addr    = AW'(page_word);
  assign xfer_mode    = cfg.mode;
  assign xfer_lanes   = lanes_of(cfg.mode);
  assign xfer_clk_sel = cfg.clk_sel;
  assign xfer_decomp  = cfg.decomp;

endmodule

// File: rtl/cfg_boot_seq_chk.sv
module cfg_boot_seq_chk #(
  parameter int AW   = 20,
  parameter int NOPT = 32,
  parameter logic [AW-1:0] BASE = 20'h08000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          status_n,
  input logic          conf_done,
  input logic          flash_req,
  input logic          flash_valid,
  input logic [AW-1:0] flash_addr,
  input logic          xfer_start,
  input logic [AW-1:0] xfer_addr,
  input logic          cfg_done,
  input logic          cfg_error,
  input logic          opt_last,
  input logic          page_cap
);

  assert_addr_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flash_req |-> (flash_addr >= BASE) && (flash_addr < BASE + AW'(NOPT)));

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_req && !flash_valid) |=> flash_req && $stable(flash_addr));

  assert_no_start_while_reading_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flash_req |-> !xfer_start);

  assert_start_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_start) |-> $past(status_n) && !$past(conf_done));

  assert_capture_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    opt_last |=> page_cap);

  assert_addr_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && $past(xfer_start)) |-> $stable(xfer_addr));

  assert_error_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !status_n) |=> cfg_error && !xfer_start);

  assert_error_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> cfg_error);

  assert_done_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && status_n && conf_done) |=> cfg_done && !xfer_start);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_start, cfg_done, cfg_error}));

endmodule

bind cfg_boot_seq cfg_boot_seq_chk #(.AW(AW), .NOPT(NOPT), .BASE(BASE)) chk_i (
  .clk(clk), .rst_n(rst_n), .status_n(status_n), .conf_done(conf_done),
  .flash_req(flash_req), .flash_valid(flash_valid), .flash_addr(flash_addr),
  .xfer_start(xfer_start), .xfer_addr(xfer_addr), .cfg_done(cfg_done),
  .cfg_error(cfg_error), .opt_last(opt_last), .page_cap(page_cap)
);

// File: tb/cfg_boot_seq_tb_top.sv
module cfg_boot_seq_tb_top;

  localparam logic [19:0] BASE = 20'h08000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  page_sel = 3'd0;
  logic        status_n = 1'b0;
  logic        conf_done = 1'b0;
  logic        flash_req;
  logic [19:0] flash_addr;
  logic        flash_valid = 1'b0;
  logic [15:0] flash_rdata = '0;
  logic        xfer_start;
  logic [19:0] xfer_addr;
  logic [2:0]  xfer_mode;
  logic [3:0]  xfer_lanes;
  logic [3:0]  xfer_clk_sel;
  logic        xfer_decomp;
  logic        cfg_done;
  logic        cfg_error;

  always #10 clk = ~clk;

  cfg_boot_seq dut_i (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .status_n(status_n),
    .conf_done(conf_done), .flash_req(flash_req), .flash_addr(flash_addr),
    .flash_valid(flash_valid), .flash_rdata(flash_rdata),
    .xfer_start(xfer_start), .xfer_addr(xfer_addr), .xfer_mode(xfer_mode),
    .xfer_lanes(xfer_lanes), .xfer_clk_sel(xfer_clk_sel),
    .xfer_decomp(xfer_decomp), .cfg_done(cfg_done), .cfg_error(cfg_error)
  );

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  int lat = 0;
  int fcnt = 0;
  logic [15:0] mem [32];
  logic [19:0] addr_q [$];
  logic [31:0] res_q [$];
  logic        start_seen = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Flash model: answers one request after lat idle cycles.
  always @(posedge clk) begin
    if (flash_valid) flash_valid <= 1'b0;
    else if (flash_req) begin
      if (fcnt == lat) begin
        flash_valid <= 1'b1;
        flash_rdata <= mem[flash_addr[4:0]];
        fcnt <= 0;
      end else fcnt <= fcnt + 1;
    end else fcnt <= 0;
  end

  // Monitor: pops expected reads and expected start settings.
  always @(negedge clk) begin
    if (rst_n && flash_req && flash_valid) begin
      rd_cnt <= rd_cnt + 1;
      if (addr_q.size() == 0) check("R1 extra read", {12'd0, flash_addr}, 32'hFFFFFFFF);
      else check("R1 read address", {12'd0, flash_addr}, {12'd0, addr_q.pop_front()});
    end
    if (rst_n && xfer_start && !start_seen) begin
      start_seen <= 1'b1;
      if (res_q.size() == 0) check("R7 unexpected start", 32'd1, 32'd0);
      else check("R3,R4,R5 start settings",
                 {xfer_addr, xfer_mode, xfer_lanes, xfer_clk_sel, xfer_decomp},
                 res_q.pop_front());
    end
    if (!xfer_start) start_seen <= 1'b0;
  end

  function automatic logic [3:0] exp_lanes(input int m);
    if (m < 4) return 4'(1 << m);
    if (m == 4) return 4'd8;
    return 4'd1;
  endfunction

  // Driver: loads flash image and pushes expected items.
  task automatic prepare(input int l, input int mode, input int cks, input int dec,
                         input logic [15:0] seed, input int psel);
    logic [15:0] pw;
    lat = l;
    for (int i = 0; i < 32; i++) mem[i] = 16'hA5A5 ^ 16'(i * 16'h0307);
    mem[0] = {7'h55, 1'(dec), 4'(cks), 1'b1, 3'(mode)};
    for (int p = 0; p < 8; p++) mem[p + 1] = seed + 16'(p * 16'h0111);
    for (int i = 0; i < 32; i++) addr_q.push_back(BASE + 20'(i));
    pw = mem[psel + 1];
    res_q.push_back({{4'd0, pw}, 3'(mode), exp_lanes(mode), 4'(cks), 1'(dec)});
    page_sel = 3'(psel);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 reset outputs", {28'd0, flash_req, xfer_start, cfg_done, cfg_error}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic wait_reads();
    int base = rd_cnt;
    int guard = 0;
    while (rd_cnt < base + 32 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check("R1 all option reads done", 32'(rd_cnt - base), 32'd32);
    repeat (2) @(negedge clk);
    check("R1 no read after option block", {31'd0, flash_req}, 32'd0);
    check("R1 expected reads consumed", 32'(addr_q.size()), 32'd0);
  endtask

  task automatic wait_start(input string req);
    int guard = 0;
    while (!xfer_start && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    check(req, {31'd0, xfer_start}, 32'd1);
  endtask

  initial begin
    // Run A: page 3, target not ready until after page_sel moves.
    status_n = 1'b0; conf_done = 1'b0;
    prepare(2, 2, 5, 1, 16'h0100, 3);
    do_reset();
    wait_reads();
    repeat (4) @(negedge clk);
    page_sel = 3'd6;
    repeat (3) @(negedge clk);
    check("R7 no start while status_n low", {31'd0, xfer_start}, 32'd0);
    status_n = 1'b1;
    @(negedge clk);
    check("R7 start one cycle after ready", {31'd0, xfer_start}, 32'd1);
    check("R6 late page_sel ignored", {12'd0, xfer_addr}, {16'd0, 16'h0100 + 16'h0333});
    repeat (3) @(negedge clk);
    conf_done = 1'b1;
    @(negedge clk);
    check("R9 done outcome", {30'd0, cfg_done, xfer_start}, 32'd2);
    conf_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 done sticky", {30'd0, cfg_done, cfg_error}, 32'd2);

    // Run B: byte-parallel mode, page 7, conf_done high blocks start.
    status_n = 1'b1; conf_done = 1'b1;
    prepare(0, 4, 10, 0, 16'h2000, 7);
    do_reset();
    wait_reads();
    repeat (5) @(negedge clk);
    check("R7 conf_done high blocks start", {31'd0, xfer_start}, 32'd0);
    conf_done = 1'b0;
    @(negedge clk);
    check("R7 start after conf_done low", {31'd0, xfer_start}, 32'd1);
    repeat (2) @(negedge clk);
    status_n = 1'b0;
    @(negedge clk);
    check("R8 error outcome", {30'd0, cfg_error, xfer_start}, 32'd2);
    status_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 error sticky", {30'd0, cfg_error, xfer_start}, 32'd2);

    // Run C: reserved mode, page 0, ready at once, collision of outcomes.
    status_n = 1'b1; conf_done = 1'b0;
    prepare(3, 6, 15, 1, 16'h7FF0, 0);
    do_reset();
    wait_reads();
    wait_start("R7 start when already ready");
    check("R4 reserved mode gives one lane", {28'd0, xfer_lanes}, 32'd1);
    status_n = 1'b0; conf_done = 1'b1;
    @(negedge clk);
    check("R10 error wins over done", {29'd0, cfg_error, cfg_done, xfer_start}, 32'd4);

    // Run D: eight-lane serial mode, page 1, normal completion.
    status_n = 1'b1; conf_done = 1'b0;
    prepare(1, 3, 0, 0, 16'h4321, 1);
    do_reset();
    wait_reads();
    wait_start("R7 start in run D");
    check("R3 clock select and decompress", {27'd0, xfer_clk_sel, xfer_decomp}, 32'd0);
    conf_done = 1'b1;
    @(negedge clk);
    check("R9 done in run D", {30'd0, cfg_done, xfer_start}, 32'd2);
    check("R5 all expected starts seen", 32'(res_q.size()), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule